// File: doc/BRIEF.md
# Operand Address Generator

This block turns one decoded operand specifier into a memory address. It receives a mode selector, the operand size, the contents of the chosen base address register, an optional index register, the current program counter and the extension field that came after the opcode. From these it forms the effective address. For auto-stepping modes it also forms the new base-register value and a write-back strobe. Modes that name a register or an immediate constant have no memory operand, and the block says so on a flag.

A pipeline pulses `start` for one cycle while its inputs are steady. One cycle later `valid` pulses and all outputs show the result. The outputs then hold until the next `start`. All sums wrap modulo 2^32. Mode decoding from the opcode, instruction fetch and the memory access itself are done elsewhere.

Top module: `ea_agen`

## Requirements
- R1: A `start` sampled high at a rising edge makes `valid` high for exactly the following cycle, with results from the inputs sampled at that edge. Without `start`, `valid` is low and `ea`, `areg_new`, `areg_we` and `no_mem` keep their values.
- R2: Mode 2 (register indirect) gives `ea` = `areg`, with `areg_we` = 0 and `areg_new` = `areg`.
- R3: Mode 3 (post-increment) gives `ea` = `areg`, `areg_new` = `areg` + step and `areg_we` = 1. The step is 1 for `op_size` 0 (byte), 2 for 1 (word) and 4 for 2 (long).
- R4: Mode 4 (pre-decrement) gives `ea` = `areg_new` = `areg` − step, with the same steps as R3, and `areg_we` = 1.
- R5: Mode 5 (base plus displacement) gives `areg` plus the sign-extended `ext[15:0]`. `ext[31:16]` has no effect.
- R6: Mode 6 (base plus index) gives `areg` + index + the sign-extended `ext[7:0]`. The index is the sign-extended `xreg[15:0]` when `xlong` = 0 and the full `xreg` when `xlong` = 1.
- R7: Mode 7 gives `pc` plus the sign-extended `ext[15:0]`. Mode 8 gives `pc` + index + the sign-extended `ext[7:0]`, with the index chosen as in R6.
- R8: Mode 9 (short absolute) gives the sign-extended `ext[15:0]`. Mode 10 (long absolute) gives `ext` unchanged.
- R9: Modes 0, 1 and 11 (data register, address register, immediate) and the unused codes 12–15 give `no_mem` = 1, `ea` = 0, `areg_we` = 0 and `areg_new` = `areg`. All other modes give `no_mem` = 0.
- R10: All address sums wrap modulo 2^32.
- R11: After reset, `valid`, `areg_we` and `no_mem` are 0 and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Compute strobe |
| mode | input | 4 | Addressing-mode selector |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| areg | input | 32 | Base address register value |
| xreg | input | 32 | Index register value |
| xlong | input | 1 | 1: full index register, 0: sign-extended low word |
| pc | input | 32 | Program counter |
| ext | input | 32 | Extension field (displacement or absolute address) |
| valid | output | 1 | Result strobe, one cycle after start |
| ea | output | 32 | Effective address |
| no_mem | output | 1 | Operand has no memory address |
| areg_new | output | 32 | Updated base register value |
| areg_we | output | 1 | Base register write-back enable |

## Verification
The assertions assume that `start` is sampled only on edges where the mode, size and operand inputs are settled. They assume that `op_size` is 0, 1 or 2 whenever an auto-stepping mode is requested, because the step checks accept only 1, 2 or 4. The stimulus drives every input on the falling edge, together with `start`, and never uses the reserved size code. Wrap-around cases come from base and PC values chosen near both ends of the address space.

// File: rtl/ea_agen_pkg.sv
package ea_agen_pkg;

  typedef enum logic [3:0] {
    EA_DREG    = 4'd0,
    EA_AREG    = 4'd1,
    EA_IND     = 4'd2,
    EA_POSTINC = 4'd3,
    EA_PREDEC  = 4'd4,
    EA_DISP    = 4'd5,
    EA_INDEX   = 4'd6,
    EA_PCDISP  = 4'd7,
    EA_PCINDEX = 4'd8,
    EA_ABSW    = 4'd9,
    EA_ABSL    = 4'd10,
    EA_IMM     = 4'd11
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } op_size_e;

  // Byte count of one operand; the reserved code is handled like a long
  function automatic int unsigned size_bytes(op_size_e sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ea_step_gen.sv
module ea_step_gen
  import ea_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  op_size_e        size,
  output logic [AW-1:0]   step
);
  localparam int SW = 3;

  logic [SW-1:0] step_small;

  always_comb begin
    step_small = SW'(size_bytes(size));
    step       = {{(AW-SW){1'b0}}, step_small};
  end

  // R3: the auto step is always a single power of two
  always_comb begin
    a_r3_step_pow2: assert ($countones(step_small) == 1);
  end
endmodule

// File: rtl/ea_index_term.sv
module ea_index_term #(
  parameter int AW  = 32,
  parameter int XW  = 16,
  parameter int D8W = 8
) (
  input  logic [AW-1:0]  xreg,
  input  logic           xlong,
  input  logic [D8W-1:0] disp8,
  output logic [AW-1:0]  term
);
  function automatic logic [AW-1:0] sext_x(logic [XW-1:0] v);
    return {{(AW-XW){v[XW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] sext_d(logic [D8W-1:0] v);
    return {{(AW-D8W){v[D8W-1]}}, v};
  endfunction

  logic [AW-1:0] idx_val;

  generate
    if (AW > XW) begin : g_wide
      assign idx_val = xlong ? xreg : sext_x(xreg[XW-1:0]);
    end else begin : g_narrow
      assign idx_val = xreg;
    end
  endgenerate

  assign term = idx_val + sext_d(disp8);
endmodule

// File: rtl/ea_addr_core.sv
module ea_addr_core
  import ea_agen_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int D8W = 8
) (
  input  ea_mode_e        mode,
  input  op_size_e        size,
  input  logic [AW-1:0]   areg,
  input  logic [AW-1:0]   xreg,
  input  logic            xlong,
  input  logic [AW-1:0]   pc,
  input  logic [AW-1:0]   ext,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   an_next,
  output logic            an_we,
  output logic            no_mem
);
  function automatic logic [AW-1:0] sext_disp(logic [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  logic [AW-1:0] step;
  logic [AW-1:0] xterm;
  logic [AW-1:0] d16;
  logic [AW-1:0] an_inc;
  logic [AW-1:0] an_dec;

  ea_step_gen #(.AW(AW)) u_step (
    .size (size),
    .step (step)
  );

  ea_index_term #(.AW(AW), .XW(DW), .D8W(D8W)) u_index (
    .xreg  (xreg),
    .xlong (xlong),
    .disp8 (ext[D8W-1:0]),
    .term  (xterm)
  );

  assign d16    = sext_disp(ext[DW-1:0]);
  assign an_inc = areg + step;
  assign an_dec = areg - step;

  always_comb begin
    ea      = '0;
    an_next = areg;
    an_we   = 1'b0;
    no_mem  = 1'b0;
    case (mode)
      EA_IND:     ea = areg;
      EA_POSTINC: begin
        ea      = areg;
        an_next = an_inc;
        an_we   = 1'b1;
      end
      EA_PREDEC:  begin
        ea      = an_dec;
        an_next = an_dec;
        an_we   = 1'b1;
      end
      EA_DISP:    ea = areg + d16;
      EA_INDEX:   ea = areg + xterm;
      EA_PCDISP:  ea = pc + d16;
      EA_PCINDEX: ea = pc + xterm;
      EA_ABSW:    ea = d16;
      EA_ABSL:    ea = ext;
      default:    no_mem = 1'b1;
    endcase
  end

  // R9: a register or immediate operand never writes back
  always_comb begin
    a_r9_nomem_comb: assert (!(no_mem && an_we));
  end
endmodule

// File: rtl/ea_agen.sv
module ea_agen
  import ea_agen_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int D8W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] xreg,
  input  logic          xlong,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ext,
  output logic          valid,
  output logic [AW-1:0] ea,
  output logic          no_mem,
  output logic [AW-1:0] areg_new,
  output logic          areg_we
);
  ea_mode_e      mode_e;
  ea_mode_e      mode_q;
  logic [AW-1:0] core_ea;
  logic [AW-1:0] core_an;
  logic          core_we;
  logic          core_nm;

  assign mode_e = ea_mode_e'(mode);

  ea_addr_core #(.AW(AW), .DW(DW), .D8W(D8W)) u_core (
    .mode    (mode_e),
    .size    (op_size_e'(op_size)),
    .areg    (areg),
    .xreg    (xreg),
    .xlong   (xlong),
    .pc      (pc),
    .ext     (ext),
    .ea      (core_ea),
    .an_next (core_an),
    .an_we   (core_we),
    .no_mem  (core_nm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      ea       <= '0;
      no_mem   <= 1'b0;
      areg_new <= '0;
      areg_we  <= 1'b0;
      mode_q   <= EA_DREG;
    end else begin
      valid <= start;
      if (start) begin
        ea       <= core_ea;
        no_mem   <= core_nm;
        areg_new <= core_an;
        areg_we  <= core_we;
        mode_q   <= mode_e;
      end
    end
  end

  // R1: strobe timing and holding of results
  a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  a_r1_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start));
  a_r1_hold_ea: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(ea) && $stable(areg_new) && $stable(no_mem));

  // R3: post-increment moves the register past the address by 1, 2 or 4
  a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_q == EA_POSTINC) |->
      ((areg_new - ea) == 1 || (areg_new - ea) == 2 || (areg_new - ea) == 4));

  // R4: pre-decrement writes back the very address it uses
  a_r4_predec_same: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_q == EA_PREDEC) |-> (ea == areg_new) && areg_we);

  // R9: no memory operand means a zero address and no write-back
  a_r9_nomem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    no_mem |-> !areg_we && ea == '0);

  // R2: only the two stepping modes ever write back
  a_r2_we_only_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && areg_we) |-> (mode_q == EA_POSTINC || mode_q == EA_PREDEC));
endmodule

// File: tb/ea_agen_bench.sv
module ea_agen_bench;
  typedef struct packed {
    logic [3:0]  md;
    logic [1:0]  sz;
    logic        xl;
    logic [31:0] an;
    logic [31:0] xr;
    logic [31:0] pcv;
    logic [31:0] ex;
    logic [31:0] e_ea;
    logic [31:0] e_an;
    logic        e_we;
    logic        e_nm;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R2 indirect
    '{4'd2, 2'd2, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0},
    // R3 post-increment byte, word, long (long wraps: R10)
    '{4'd3, 2'd0, 1'b0, 32'h0000_2000, 32'h0, 32'h0, 32'h0, 32'h0000_2000, 32'h0000_2001, 1'b1, 1'b0},
    '{4'd3, 2'd1, 1'b0, 32'h0000_2000, 32'h0, 32'h0, 32'h0, 32'h0000_2000, 32'h0000_2002, 1'b1, 1'b0},
    '{4'd3, 2'd2, 1'b0, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFE, 32'h0000_0002, 1'b1, 1'b0},
    // R4 pre-decrement byte, long (wraps: R10), word
    '{4'd4, 2'd0, 1'b0, 32'h0000_3000, 32'h0, 32'h0, 32'h0, 32'h0000_2FFF, 32'h0000_2FFF, 1'b1, 1'b0},
    '{4'd4, 2'd2, 1'b0, 32'h0000_0002, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 1'b1, 1'b0},
    '{4'd4, 2'd1, 1'b0, 32'h0000_3000, 32'h0, 32'h0, 32'h0, 32'h0000_2FFE, 32'h0000_2FFE, 1'b1, 1'b0},
    // R5 displacement: negative with junk upper bits, then largest positive
    '{4'd5, 2'd1, 1'b0, 32'h0000_4000, 32'h0, 32'h0, 32'hABCD_FFF0, 32'h0000_3FF0, 32'h0000_4000, 1'b0, 1'b0},
    '{4'd5, 2'd1, 1'b0, 32'h0000_4000, 32'h0, 32'h0, 32'h0000_7FFF, 32'h0000_BFFF, 32'h0000_4000, 1'b0, 1'b0},
    // R6 index: word index (-2) with -128, then long index with +127
    '{4'd6, 2'd1, 1'b0, 32'h0000_5000, 32'h1234_FFFE, 32'h0, 32'h0000_0080, 32'h0000_4F7E, 32'h0000_5000, 1'b0, 1'b0},
    '{4'd6, 2'd1, 1'b1, 32'h0000_5000, 32'h0001_0000, 32'h0, 32'h0000_007F, 32'h0001_507F, 32'h0000_5000, 1'b0, 1'b0},
    // R7 PC displacement and PC with index
    '{4'd7, 2'd1, 1'b0, 32'h0000_7777, 32'h0, 32'h0010_0000, 32'h0000_8000, 32'h000F_8000, 32'h0000_7777, 1'b0, 1'b0},
    '{4'd8, 2'd1, 1'b0, 32'h0000_7777, 32'h0000_0010, 32'h0010_0000, 32'h0000_00FC, 32'h0010_000C, 32'h0000_7777, 1'b0, 1'b0},
    // R8 short absolute (negative, positive with junk) and long absolute
    '{4'd9, 2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0000_8000, 32'hFFFF_8000, 32'h0, 1'b0, 1'b0},
    '{4'd9, 2'd1, 1'b0, 32'h0, 32'h0, 32'h0, 32'hFFFF_1234, 32'h0000_1234, 32'h0, 1'b0, 1'b0},
    '{4'd10, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'h1234_5678, 32'h0, 1'b0, 1'b0},
    // R9 data register, address register, immediate
    '{4'd0, 2'd2, 1'b0, 32'h0000_9999, 32'h0, 32'h0, 32'h1111_1111, 32'h0, 32'h0000_9999, 1'b0, 1'b1},
    '{4'd1, 2'd0, 1'b0, 32'h0000_AAAA, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_AAAA, 1'b0, 1'b1},
    '{4'd11, 2'd1, 1'b0, 32'h0000_BBBB, 32'h0, 32'h0, 32'h0000_1234, 32'h0, 32'h0000_BBBB, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] areg = '0;
  logic [31:0] xreg = '0;
  logic        xlong = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] ext = '0;
  logic        valid;
  logic [31:0] ea;
  logic        no_mem;
  logic [31:0] areg_new;
  logic        areg_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ea_agen u_ea_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_size(op_size),
    .areg(areg), .xreg(xreg), .xlong(xlong), .pc(pc), .ext(ext),
    .valid(valid), .ea(ea), .no_mem(no_mem), .areg_new(areg_new), .areg_we(areg_we)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    mode = v.md; op_size = v.sz; xlong = v.xl; areg = v.an;
    xreg = v.xr; pc = v.pcv; ext = v.ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 32'(valid), 32'd0);
    check("R11 ea", ea, 32'd0);
    check("R11 we", 32'(areg_we), 32'd0);
    check("R11 no_mem", 32'(no_mem), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check("R1 valid", 32'(valid), 32'd1);
      check("R2-R10 ea", ea, VECS[i].e_ea);
      check("R2-R10 areg_new", areg_new, VECS[i].e_an);
      check("R3/R4 we", 32'(areg_we), 32'(VECS[i].e_we));
      check("R9 no_mem", 32'(no_mem), 32'(VECS[i].e_nm));
    end

    // R1: a single-cycle strobe, then results hold while inputs change
    apply(VECS[3]);
    mode = 4'd10; ext = 32'hDEAD_BEEF; areg = 32'h0;
    @(negedge clk);
    check("R1 valid drops", 32'(valid), 32'd0);
    check("R1 ea held", ea, 32'hFFFF_FFFE);
    check("R1 areg_new held", areg_new, 32'h0000_0002);
    repeat (3) @(negedge clk);
    check("R1 ea still held", ea, 32'hFFFF_FFFE);

    // R9: unused mode code 13 has no memory operand
    apply('{4'd13, 2'd2, 1'b0, 32'h0000_C0DE, 32'h0, 32'h0, 32'h5555_5555,
            32'h0, 32'h0000_C0DE, 1'b0, 1'b1});
    check("R9 reserved no_mem", 32'(no_mem), 32'd1);
    check("R9 reserved ea", ea, 32'd0);
    check("R9 reserved areg_new", areg_new, 32'h0000_C0DE);

    // R7/R10: PC near the top wraps past zero
    apply('{4'd7, 2'd1, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'h0000_0020,
            32'h0000_0010, 32'h0, 1'b0, 1'b0});
    check("R10 pc wrap", ea, 32'h0000_0010);

    // R6: word index ignores upper half of index register
    apply('{4'd6, 2'd1, 1'b0, 32'h0000_1000, 32'h7FFF_0004, 32'h0, 32'h0000_0000,
            32'h0000_1004, 32'h0000_1000, 1'b0, 1'b0});
    check("R6 word index", ea, 32'h0000_1004);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule